// File: doc/BRIEF.md
# Second-Stage Address Translator with Lookaside Cache

This block turns a 32-bit guest intermediate address into a host physical address for whichever guest currently runs on one core. It first compares the page number against a small fully associative cache of recent translations. On a hit, the result comes back one cycle after the request is accepted. On a miss, it walks a two-level tree of word tables in memory and then appends a 12-bit byte offset. The walk starts from a per-core table root register.

A successful walk is written into the cache. When no slot is free, slots are replaced in round-robin order. A missing table entry at either level ends the walk with a fault and no address, and the fault is not cached. The scheduler reloads the root register whenever it switches guests, and that reload empties the cache. A separate strobe also empties the cache.

Top module: `slat_xlate`

## Requirements
- R1: The upper 10 address bits [31:22] select the first fetch, which reads the word at root + 4 × index.
- R2: The second fetch reads the word at {first entry bits [31:12], 12'h000} + 4 × address bits [21:12].
- R3: After a valid second entry, the physical address is {second entry bits [31:12], request bits [11:0]} with the fault flag low.
- R4: A table word with bit 0 clear ends the walk at that level. The response then has fault high and address zero, and no further fetch is made.
- R5: A cached page returns its translation in the cycle after acceptance and makes no memory fetch.
- R6: A completed walk is cached, so the same page then hits. No page ever matches more than one slot.
- R7: Faulting walks are not cached: repeating a faulting address walks the tables again.
- R8: The cache holds 16 pages. Fills go round-robin from slot 0 after an empty cache, so the 17th distinct fill evicts the first page filled.
- R9: A flush pulse invalidates every cached page.
- R10: Loading a new root value flushes the cache, and later walks start at the new root.
- R11: req_ready is low while a walk is in progress. Each fetch raises mem_req for one cycle and holds mem_addr until mem_valid.
- R12: After reset, req_ready is 1, and rsp_valid and mem_req are 0.
- R13: The response repeats the request's write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Intermediate address |
| req_write | input | 1 | Access is a write |
| req_ready | output | 1 | Request accepted when high |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Second-stage fault |
| rsp_write | output | 1 | Write flag of the request |
| mem_req | output | 1 | Table fetch pulse |
| mem_addr | output | 32 | Table word address |
| mem_valid | input | 1 | Fetch data valid |
| mem_rdata | input | 32 | Fetched table word |
| base_load | input | 1 | Load table root (guest switch) |
| base_value | input | 32 | New table root |
| flush | input | 1 | Invalidate all cached pages |

## Verification
The bench sends a fully mapped address twice. The first pass checks both fetch addresses and the final address, and the second pass checks that the hit makes no fetch and arrives one cycle after acceptance. Addresses with a hole at the first level and at the second level give faults after one and two fetches, and repeating them shows that faults are never cached. A flush, a root switch that maps the same page to a new frame, and seventeen distinct pages followed by a miss on the first page and a hit on the third separate the flush behaviour from the replacement order. Memory latency varies between one and three cycles to test that the fetch address is held while waiting.

// File: rtl/slat_pkg.sv
package slat_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_L1_REQ,
      ST_L1_WAIT,
      ST_L2_REQ,
      ST_L2_WAIT
   } walk_st_t;

endpackage

// File: rtl/slat_tlb.sv
module slat_tlb #(
   parameter int PN_W  = 20,
   parameter int DEPTH = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic [PN_W-1:0] lk_vpn,
   output logic            lk_hit,
   output logic [PN_W-1:0] lk_ppn,
   input  logic            fill_en,
   input  logic [PN_W-1:0] fill_vpn,
   input  logic [PN_W-1:0] fill_ppn
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("slat_tlb: DEPTH must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] valid_q;
   logic [PN_W-1:0]  vpn_q [DEPTH];
   logic [PN_W-1:0]  ppn_q [DEPTH];
   logic [DEPTH-1:0] match;
   logic [IDX_W-1:0] victim_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign match[i] = valid_q[i] && (vpn_q[i] == lk_vpn);
   end

   always_comb begin
      lk_ppn = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (match[i]) lk_ppn = lk_ppn | ppn_q[i];
      end
   end
   assign lk_hit = |match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= '0;
         victim_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            vpn_q[i] <= '0;
            ppn_q[i] <= '0;
         end
      end else if (flush) begin
         valid_q  <= '0;
         victim_q <= '0;
      end else if (fill_en) begin
         valid_q[victim_q] <= 1'b1;
         vpn_q[victim_q]   <= fill_vpn;
         ppn_q[victim_q]   <= fill_ppn;
         victim_q          <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
      end
   end

   // R9
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));

   // R6
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

endmodule

// File: rtl/slat_walker.sv
module slat_walker
   import slat_pkg::*;
#(
   parameter int AW    = 32,
   parameter int TOP_W = 10,
   parameter int MID_W = 10,
   parameter int OFF_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [AW-1:0]      req_addr,
   input  logic               req_write,
   output logic               req_ready,
   input  logic [AW-1:0]      base_q,
   input  logic               stale,
   input  logic               tlb_hit,
   input  logic [AW-OFF_W-1:0] tlb_ppn,
   output logic               fill_en,
   output logic [AW-OFF_W-1:0] fill_vpn,
   output logic [AW-OFF_W-1:0] fill_ppn,
   output logic               mem_req,
   output logic [AW-1:0]      mem_addr,
   input  logic               mem_valid,
   input  logic [AW-1:0]      mem_rdata,
   output logic               rsp_valid,
   output logic [AW-1:0]      rsp_paddr,
   output logic               rsp_fault,
   output logic               rsp_write
);

   localparam int PN_W = AW - OFF_W;

   walk_st_t        st_q;
   logic [AW-1:0]   addr_q;
   logic            wr_q;
   logic [PN_W-1:0] ptr_q;
   logic            drop_q;

   logic [TOP_W-1:0] top_idx;
   logic [MID_W-1:0] mid_idx;
   logic [AW-1:0]    l1_addr;
   logic [AW-1:0]    l2_addr;
   logic             unused_bits;

   assign top_idx     = addr_q[AW-1 -: TOP_W];
   assign mid_idx     = addr_q[OFF_W+MID_W-1 -: MID_W];
   assign l1_addr     = base_q + (AW'(top_idx) << 2);
   assign l2_addr     = {ptr_q, {OFF_W{1'b0}}} + (AW'(mid_idx) << 2);
   assign unused_bits = ^mem_rdata[OFF_W-1:1];

   assign req_ready = (st_q == ST_IDLE);
   assign mem_req   = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
   assign mem_addr  = (st_q == ST_L1_REQ || st_q == ST_L1_WAIT) ? l1_addr : l2_addr;

   assign fill_en  = (st_q == ST_L2_WAIT) && mem_valid && mem_rdata[0] && !drop_q && !stale;
   assign fill_vpn = addr_q[AW-1:OFF_W];
   assign fill_ppn = mem_rdata[AW-1:OFF_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_q    <= '0;
         wr_q      <= 1'b0;
         ptr_q     <= '0;
         drop_q    <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_fault <= 1'b0;
         rsp_write <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         if (stale) drop_q <= 1'b1;
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q <= req_addr;
                  wr_q   <= req_write;
                  drop_q <= stale;
                  if (tlb_hit) begin
                     rsp_valid <= 1'b1;
                     rsp_fault <= 1'b0;
                     rsp_paddr <= {tlb_ppn, req_addr[OFF_W-1:0]};
                     rsp_write <= req_write;
                  end else begin
                     st_q <= ST_L1_REQ;
                  end
               end
            end
            ST_L1_REQ: st_q <= ST_L1_WAIT;
            ST_L1_WAIT: begin
               if (mem_valid) begin
                  if (!mem_rdata[0]) begin
                     rsp_valid <= 1'b1;
                     rsp_fault <= 1'b1;
                     rsp_paddr <= '0;
                     rsp_write <= wr_q;
                     st_q      <= ST_IDLE;
                  end else begin
                     ptr_q <= mem_rdata[AW-1:OFF_W];
                     st_q  <= ST_L2_REQ;
                  end
               end
            end
            ST_L2_REQ: st_q <= ST_L2_WAIT;
            ST_L2_WAIT: begin
               if (mem_valid) begin
                  rsp_valid <= 1'b1;
                  rsp_write <= wr_q;
                  rsp_fault <= !mem_rdata[0];
                  rsp_paddr <= mem_rdata[0] ? {mem_rdata[AW-1:OFF_W], addr_q[OFF_W-1:0]} : '0;
                  st_q      <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R11
   mem_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R11
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   // R5
   hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && tlb_hit) |=> (rsp_valid && !rsp_fault));

   // R4
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

   // R3
   offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == addr_q[OFF_W-1:0]));

endmodule

// File: rtl/slat_xlate.sv
module slat_xlate #(
   parameter int AW        = 32,
   parameter int TOP_W     = 10,
   parameter int MID_W     = 10,
   parameter int OFF_W     = 12,
   parameter int TLB_DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   input  logic          req_write,
   output logic          req_ready,
   output logic          rsp_valid,
   output logic [AW-1:0] rsp_paddr,
   output logic          rsp_fault,
   output logic          rsp_write,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_valid,
   input  logic [AW-1:0] mem_rdata,
   input  logic          base_load,
   input  logic [AW-1:0] base_value,
   input  logic          flush
);

   localparam int PN_W = AW - OFF_W;

   generate
      if (TOP_W + MID_W + OFF_W != AW) begin : g_bad_split
         $error("slat_xlate: index and offset widths must sum to AW");
      end
      if (TOP_W + 2 > OFF_W || MID_W + 2 > OFF_W) begin : g_bad_table
         $error("slat_xlate: a table of words must fit in one page");
      end
   endgenerate

   logic [AW-1:0]   base_q;
   logic            flush_all;
   logic            tlb_hit;
   logic [PN_W-1:0] tlb_ppn;
   logic            fill_en;
   logic [PN_W-1:0] fill_vpn;
   logic [PN_W-1:0] fill_ppn;

   assign flush_all = flush || base_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         base_q <= '0;
      else if (base_load) base_q <= base_value;
   end

   slat_tlb #(
      .PN_W  (PN_W),
      .DEPTH (TLB_DEPTH)
   ) u_tlb (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush_all),
      .lk_vpn   (req_addr[AW-1:OFF_W]),
      .lk_hit   (tlb_hit),
      .lk_ppn   (tlb_ppn),
      .fill_en  (fill_en),
      .fill_vpn (fill_vpn),
      .fill_ppn (fill_ppn)
   );

   slat_walker #(
      .AW    (AW),
      .TOP_W (TOP_W),
      .MID_W (MID_W),
      .OFF_W (OFF_W)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_write (req_write),
      .req_ready (req_ready),
      .base_q    (base_q),
      .stale     (flush_all),
      .tlb_hit   (tlb_hit),
      .tlb_ppn   (tlb_ppn),
      .fill_en   (fill_en),
      .fill_vpn  (fill_vpn),
      .fill_ppn  (fill_ppn),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_valid (mem_valid),
      .mem_rdata (mem_rdata),
      .rsp_valid (rsp_valid),
      .rsp_paddr (rsp_paddr),
      .rsp_fault (rsp_fault),
      .rsp_write (rsp_write)
   );

   // R10
   base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_load |=> (base_q == $past(base_value)));

endmodule

// File: tb/slat_xlate_tb.sv
module slat_xlate_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_ready;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic        rsp_write;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        base_load = 1'b0;
   logic [31:0] base_value = '0;
   logic        flush = 1'b0;

   always #5 clk = ~clk;

   slat_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_write(rsp_write),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_rdata(mem_rdata), .base_load(base_load), .base_value(base_value),
      .flush(flush)
   );

   typedef struct {
      logic [31:0] pa;
      logic        fault;
      logic        wr;
      int          nf;
      bit          hit;
      int          acc;
      int          f0;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   logic [31:0] fq[$];
   string       ftag[$];
   logic [31:0] mem [logic [31:0]];
   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int fetch_cnt = 0;
   int resp_cnt = 0;
   int mem_lat = 1;
   logic [31:0] cur_base = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic map_page(input logic [31:0] base, input logic [31:0] va,
                           input logic [31:0] l2, input logic [19:0] ppn);
      mem[base + {20'h0, va[31:22], 2'b00}] = l2 | 32'h1;
      mem[l2 + {20'h0, va[21:12], 2'b00}]   = {ppn, 12'h001};
   endtask

   // memory responder: checks fetch addresses (R1, R2) and hold (R11)
   initial begin
      forever begin
         @(negedge clk);
         mem_valid = 1'b0;
         if (mem_req) begin
            logic [31:0] a;
            a = mem_addr;
            fetch_cnt++;
            if (fq.size() == 0) begin
               check(1'b0, "R5", "fetch while none expected", a, 32'h0);
            end else begin
               logic [31:0] e;
               string t;
               e = fq.pop_front();
               t = ftag.pop_front();
               check(a == e, t, "fetch address", a, e);
            end
            repeat (mem_lat) @(negedge clk);
            check(mem_addr == a, "R11", "fetch address held", mem_addr, a);
            mem_valid = 1'b1;
            mem_rdata = rd(a);
         end
      end
   end

   // monitor: pops the scoreboard on each response
   initial begin
      forever begin
         @(negedge clk);
         if (rsp_valid) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R12", "response with none expected", rsp_paddr, 32'h0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               check(rsp_fault == e.fault, e.tag, "fault flag", 32'(rsp_fault), 32'(e.fault));
               check(rsp_paddr == e.pa, e.tag, "physical address", rsp_paddr, e.pa);
               // R13
               check(rsp_write == e.wr, "R13", "write flag", 32'(rsp_write), 32'(e.wr));
               check(fetch_cnt - e.f0 == e.nf, e.tag, "fetch count",
                     32'(fetch_cnt - e.f0), 32'(e.nf));
               if (e.hit)
                  check(cyc - e.acc == 1, "R5", "hit latency", 32'(cyc - e.acc), 32'd1);
            end
            resp_cnt++;
         end
      end
   end

   task automatic xlate(input logic [31:0] va, input bit wr, input bit hit,
                        input int lat, input string tag);
      exp_t e;
      logic [31:0] f1, f2, e1, e2;
      int n;
      f1 = cur_base + {20'h0, va[31:22], 2'b00};
      e1 = rd(f1);
      f2 = {e1[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
      e2 = rd(f2);
      e.wr = wr; e.hit = hit; e.tag = tag;
      if (!e1[0]) begin
         e.fault = 1'b1; e.pa = 32'h0; e.nf = 1;
      end else if (!e2[0]) begin
         e.fault = 1'b1; e.pa = 32'h0; e.nf = 2;
      end else begin
         e.fault = 1'b0; e.pa = {e2[31:12], va[11:0]}; e.nf = 2;
      end
      if (hit) e.nf = 0;
      if (!hit) begin
         fq.push_back(f1); ftag.push_back("R1");
         if (e.nf == 2) begin fq.push_back(f2); ftag.push_back("R2"); end
      end
      mem_lat = lat;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      e.acc = cyc;
      e.f0 = fetch_cnt;
      sb_q.push_back(e);
      n = resp_cnt;
      req_valid = 1'b1; req_addr = va; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      if (!hit) check(req_ready == 1'b0, "R11", "ready low during walk", 32'(req_ready), 32'd0);
      while (resp_cnt == n) @(negedge clk);
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
   endtask

   task automatic load_base(input logic [31:0] b);
      @(negedge clk); base_load = 1'b1; base_value = b;
      @(negedge clk); base_load = 1'b0;
      cur_base = b;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   localparam logic [31:0] BASE_A = 32'h0010_0000;
   localparam logic [31:0] BASE_B = 32'h0020_0000;
   localparam logic [31:0] VA1    = 32'h0040_1234;

   initial begin
      map_page(BASE_A, VA1, 32'h0050_0000, 20'hABCDE);
      map_page(BASE_B, VA1, 32'h0060_0000, 20'h12345);
      for (int i = 0; i < 17; i++)
         map_page(BASE_B, 32'h00C0_0000 + (i << 12), 32'h0070_0000, 20'h20000 + i[19:0]);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12
      check(req_ready == 1'b1, "R12", "ready after reset", 32'(req_ready), 32'd1);
      check(rsp_valid == 1'b0, "R12", "no response after reset", 32'(rsp_valid), 32'd0);
      check(mem_req == 1'b0, "R12", "no fetch after reset", 32'(mem_req), 32'd0);

      load_base(BASE_A);
      xlate(VA1, 1'b1, 1'b0, 1, "R3");            // full walk
      xlate(VA1, 1'b0, 1'b1, 1, "R6");            // cached
      xlate(32'h0800_0010, 1'b0, 1'b0, 2, "R4");  // hole at first level
      xlate(32'h0800_0010, 1'b1, 1'b0, 3, "R7");  // fault not cached
      xlate(32'h0040_5abc, 1'b0, 1'b0, 2, "R4");  // hole at second level
      xlate(32'h0040_5abc, 1'b0, 1'b0, 1, "R7");
      xlate(VA1, 1'b1, 1'b1, 1, "R5");

      do_flush();
      xlate(VA1, 1'b0, 1'b0, 3, "R9");            // flushed: walks again
      xlate(VA1, 1'b0, 1'b1, 1, "R5");

      load_base(BASE_B);
      xlate(VA1, 1'b0, 1'b0, 2, "R10");           // new root, new frame
      xlate(VA1, 1'b1, 1'b1, 1, "R10");

      load_base(BASE_B);                          // empty cache, slot 0 first
      for (int i = 0; i < 17; i++)
         xlate(32'h00C0_0000 + (i << 12) + 32'h0ff, 1'b0, 1'b0, 1, "R8");
      xlate(32'h00C0_0004, 1'b0, 1'b0, 1, "R8");  // first page evicted
      xlate(32'h00C0_2008, 1'b0, 1'b1, 1, "R8");  // third page kept
      xlate(32'h00C1_0000, 1'b0, 1'b1, 1, "R8");  // seventeenth page kept

      repeat (3) @(negedge clk);
      check(fq.size() == 0, "R11", "all expected fetches issued", 32'(fq.size()), 32'd0);
      finish_run();
   end

endmodule